// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to 32 interrupt sources into one bank of seven 32-bit memory-mapped registers. Each source owns one bit index, and that index is the same in every register of the bank. Hardware event pulses latch into a pending-cause register. Software can also raise a cause directly. A mask can be written whole, or set and cleared one bit at a time, and a masked view shows the pending causes that are not masked.

A control register chooses, per bit, how a pending cause is retired. A bit can clear when software writes one to it, or it can clear when software reads it. The same rule applies whether software goes through the raw-cause address or the masked-cause address. A single interrupt line is high while any unmasked cause is pending.

The register port has separate read and write strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A one on `hw_evt[i]` in a cycle sets cause bit i. A held level keeps setting the bit every cycle. An event beats a clear of the same bit in the same cycle, so the bit stays set.
- R3: Writing offset 0x0C sets the cause bits where the write data is one and leaves the others alone. A read of 0x0C returns zero.
- R4: A write to offset 0x04 clears each cause bit whose write-data bit is one and whose control bit is 0. Zero data bits have no effect. Bits whose control bit is 1 are not changed by writes.
- R5: A read of offset 0x04 returns the cause register. Each bit whose control bit is 1 and that was one in the returned value is then cleared. Bits with control bit 0 are not changed by reads.
- R6: A read of offset 0x08 returns cause AND NOT mask, and clears, with the R5 rule, only the bits it returned. Masked pending bits stay. A write to 0x08 clears bits with the R4 rule.
- R7: At offset 0x10 the mask is read and written whole. A one written to 0x14 sets that mask bit, and a one written to 0x18 clears it. Zeros written to 0x14 or 0x18 have no effect. Reads of 0x14 and 0x18 return the mask.
- R8: `irq` is high exactly while some bit of cause AND NOT mask is one.
- R9: The control register at offset 0x00 reads back the last value written to it. A control bit of 0 selects write-one-to-clear and a 1 selects clear-on-read.
- R10: `rdata` takes the read value in the cycle after `rd_en` and holds it until the next read. Offsets 0x1C and above, and offsets not on a 4-byte boundary, read as zero and ignore writes. When `wr_en` and `rd_en` are both high, only the write happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W (5) | Byte offset within the bank |
| wdata | input | NSRC (32) | Write data |
| rdata | output | NSRC (32) | Registered read data |
| hw_evt | input | NSRC (32) | Hardware event pulses, one per source |
| irq | output | 1 | High while any unmasked cause is pending |

## Verification
The retire paths are tried with a control word that mixes both clear rules in one bank. This shows that a write leaves clear-on-read bits alone and that a read leaves write-one-to-clear bits alone. Masked reads run with masked pending bits present among the clear-on-read bits, which separates "clears what was returned" from "clears what is pending". Events that coincide with a write-one clear, and events held as a level across a clear, show whether the set path wins. Unaligned and out-of-range offsets, and a cycle with both strobes high, show that no stray access touches the mask.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    // number of registers in the bank and their word indices
    localparam int unsigned NUM_REGS  = 7;
    localparam int unsigned IDX_CTL   = 0;
    localparam int unsigned IDX_CAUSE = 1;
    localparam int unsigned IDX_MCAUS = 2;
    localparam int unsigned IDX_CSET  = 3;
    localparam int unsigned IDX_MVAL  = 4;
    localparam int unsigned IDX_MSET  = 5;
    localparam int unsigned IDX_MCLR  = 6;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] wsel,
    output logic [NUM_REGS-1:0] rsel
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [NUM_REGS-1:0] hit;
    logic                aligned;
    logic                rd_take;

    assign aligned = (addr[1:0] == 2'b00);
    assign rd_take = rd_en && !wr_en;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g]  = aligned && (addr[ADDR_W-1:2] == IDX_W'(g));
        assign wsel[g] = hit[g] && wr_en;
        assign rsel[g] = hit[g] && rd_take;
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_val,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] mask_q
);
    typedef struct packed {
        logic [NSRC-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_val) st_d.mask = wdata;
        if (wr_set) st_d.mask = st_q.mask | wdata;
        if (wr_clr) st_d.mask = st_q.mask & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;

    // R7: bits written as one to the set address are masked afterwards
    a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R7: bits written as one to the clear address are unmasked afterwards
    a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(wdata)) == '0));

    // R7: zeros written to set or clear leave the other bits unchanged
    a_r7_mask_zero_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_evt,
    input  logic            wr_ctl,
    input  logic            wr_clr,
    input  logic            wr_set,
    input  logic            rd_raw,
    input  logic            rd_masked,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] cause_q,
    output logic [NSRC-1:0] ctl_q
);
    typedef struct packed {
        logic [NSRC-1:0] cause;
        logic [NSRC-1:0] ctl;
    } cause_state_t;

    cause_state_t    st_d, st_q;
    logic [NSRC-1:0] w1c_hit;
    logic [NSRC-1:0] read_view;
    logic [NSRC-1:0] cor_hit;
    logic [NSRC-1:0] sw_set;

    always_comb begin
        st_d      = st_q;
        w1c_hit   = wr_clr ? (wdata & ~st_q.ctl) : '0;
        read_view = '0;
        if (rd_raw)    read_view = st_q.cause;
        if (rd_masked) read_view = st_q.cause & ~mask;
        cor_hit   = read_view & st_q.ctl;
        sw_set    = wr_set ? wdata : '0;
        // events and software sets win over any clear in the same cycle
        st_d.cause = (st_q.cause & ~(w1c_hit | cor_hit)) | sw_set | hw_evt;
        if (wr_ctl) st_d.ctl = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_q = st_q.cause;
    assign ctl_q   = st_q.ctl;

    // R2: every event bit is pending in the following cycle
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((cause_q & $past(hw_evt)) == $past(hw_evt)));

    // R3: a software set makes the written bits pending
    a_r3_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((cause_q & $past(wdata)) == $past(wdata)));

    // R4: clear-on-read bits survive any write
    a_r4_cor_immune_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((cause_q & $past(cause_q & ctl_q)) == $past(cause_q & ctl_q)));

    // R5: write-one-to-clear bits survive a raw read
    a_r5_w1c_immune_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_raw |=> ((cause_q & $past(cause_q & ~ctl_q)) == $past(cause_q & ~ctl_q)));

    // R6: masked pending bits survive a masked-view read
    a_r6_masked_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rd_masked |=> ((cause_q & $past(cause_q & mask)) == $past(cause_q & mask)));

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSRC-1:0]   wdata,
    output logic [NSRC-1:0]   rdata,
    input  logic [NSRC-1:0]   hw_evt,
    output logic              irq
);
    typedef struct packed {
        logic [NSRC-1:0] rdata;
    } rd_state_t;

    logic [NUM_REGS-1:0] wsel;
    logic [NUM_REGS-1:0] rsel;
    logic [NSRC-1:0]     cause;
    logic [NSRC-1:0]     ctl;
    logic [NSRC-1:0]     mask;
    logic [NSRC-1:0]     rd_mux;
    rd_state_t           st_d, st_q;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wsel  (wsel),
        .rsel  (rsel)
    );

    irq_cause_reg #(.NSRC(NSRC)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_evt    (hw_evt),
        .wr_ctl    (wsel[IDX_CTL]),
        .wr_clr    (wsel[IDX_CAUSE] || wsel[IDX_MCAUS]),
        .wr_set    (wsel[IDX_CSET]),
        .rd_raw    (rsel[IDX_CAUSE]),
        .rd_masked (rsel[IDX_MCAUS]),
        .wdata     (wdata),
        .mask      (mask),
        .cause_q   (cause),
        .ctl_q     (ctl)
    );

    irq_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_val (wsel[IDX_MVAL]),
        .wr_set (wsel[IDX_MSET]),
        .wr_clr (wsel[IDX_MCLR]),
        .wdata  (wdata),
        .mask_q (mask)
    );

    always_comb begin
        rd_mux = '0;
        if (rsel[IDX_CTL])   rd_mux = ctl;
        if (rsel[IDX_CAUSE]) rd_mux = cause;
        if (rsel[IDX_MCAUS]) rd_mux = cause & ~mask;
        if (rsel[IDX_MVAL] || rsel[IDX_MSET] || rsel[IDX_MCLR]) rd_mux = mask;
        st_d = st_q;
        if (rd_en && !wr_en) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign irq   = |(cause & ~mask);

    // R10: read data holds when no read is taken
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> $stable(rdata));

    // R3: the software-set address reads as zero
    a_r3_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == ADDR_W'(4 * IDX_CSET)) |=> (rdata == '0));

    // R8: without events or accesses a raised interrupt stays raised
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en && !rd_en) |=> irq);

    // R8: without events or accesses a quiet line stays quiet
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !wr_en && !rd_en && hw_evt == '0) |=> !irq);

endmodule

// File: tb/irq_cause_bank_test.sv
module irq_cause_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] hw_evt = '0;
    logic        irq;
    int          tests = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    irq_cause_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hw_evt(hw_evt), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic clean();
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 7; i++) begin
            rd(5'(4 * i), v);
            chk("R1 reg", v, 32'h0);
        end
    endtask

    task automatic t_ctl();
        logic [31:0] v;
        wr(5'h00, 32'hA5A5_0F0F);
        rd(5'h00, v);
        chk("R9 ctl readback", v, 32'hA5A5_0F0F);
        clean();
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(5'h10, 32'h0000_FFFF);
        rd(5'h10, v);
        chk("R7 mask write", v, 32'h0000_FFFF);
        wr(5'h14, 32'h00FF_0000);
        rd(5'h10, v);
        chk("R7 mask set", v, 32'h00FF_FFFF);
        wr(5'h18, 32'h0000_00F0);
        rd(5'h14, v);
        chk("R7 mask clear", v, 32'h00FF_FF0F);
        rd(5'h18, v);
        chk("R7 clr addr read", v, 32'h00FF_FF0F);
        clean();
    endtask

    task automatic t_hw();
        logic [31:0] v;
        @(negedge clk); hw_evt = 32'h0000_0011;
        @(negedge clk); hw_evt = '0;
        chk("R8 irq on event", {31'b0, irq}, 32'h1);
        rd(5'h04, v);
        chk("R2 event latched", v, 32'h0000_0011);
        wr(5'h04, 32'h0000_0001);
        rd(5'h04, v);
        chk("R4 w1c clear", v, 32'h0000_0010);
        wr(5'h04, 32'h0);
        rd(5'h04, v);
        chk("R4 zero no effect", v, 32'h0000_0010);
        wr(5'h10, 32'h0000_0010);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        clean();
    endtask

    task automatic t_set();
        logic [31:0] v;
        wr(5'h0C, 32'h8000_0000);
        rd(5'h04, v);
        chk("R3 sw set", v, 32'h8000_0000);
        rd(5'h0C, v);
        chk("R3 set addr reads zero", v, 32'h0);
        clean();
    endtask

    task automatic t_cor();
        logic [31:0] v;
        wr(5'h00, 32'h0000_00F0);
        wr(5'h0C, 32'h0000_00FF);
        wr(5'h04, 32'h0000_00FF);
        rd(5'h04, v);
        chk("R4 cor bits keep on write", v, 32'h0000_00F0);
        rd(5'h04, v);
        chk("R5 cleared after read", v, 32'h0);
        clean();
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(5'h00, 32'h0000_00F0);
        wr(5'h0C, 32'h0000_00FF);
        wr(5'h10, 32'h0000_00CC);
        rd(5'h08, v);
        chk("R6 masked view", v, 32'h0000_0033);
        rd(5'h00, v);
        chk("R9 ctl kept", v, 32'h0000_00F0);
        chk("R8 irq unmasked low bits", {31'b0, irq}, 32'h1);
        wr(5'h04, 32'h0000_0003);
        chk("R8 irq all masked", {31'b0, irq}, 32'h0);
        rd(5'h04, v);
        chk("R6 only returned cleared", v, 32'h0000_00CC);
        wr(5'h08, 32'h0000_000C);
        rd(5'h04, v);
        chk("R6 masked addr w1c", v, 32'h0);
        clean();
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(5'h0C, 32'h0000_0004);
        @(negedge clk);
        wr_en = 1'b1; addr = 5'h04; wdata = 32'h0000_0004; hw_evt = 32'h0000_0004;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; hw_evt = '0;
        rd(5'h04, v);
        chk("R2 event beats clear", v, 32'h0000_0004);
        wr(5'h04, 32'h0000_0004);
        @(negedge clk); hw_evt = 32'h0000_0008;
        wr(5'h04, 32'h0000_0008);
        @(negedge clk); hw_evt = '0;
        rd(5'h04, v);
        chk("R2 held level", v, 32'h0000_0008);
        wr(5'h00, 32'h0000_0008);
        @(negedge clk);
        rd_en = 1'b1; addr = 5'h04; hw_evt = 32'h0000_0008;
        @(negedge clk);
        rd_en = 1'b0; hw_evt = '0;
        rd(5'h04, v);
        chk("R2 event beats read clear", v, 32'h0000_0008);
        clean();
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h12, 32'hFFFF_FFFF);
        rd(5'h10, v);
        chk("R10 stray writes ignored", v, 32'h0);
        rd(5'h1C, v);
        chk("R10 unmapped reads zero", v, 32'h0);
        wr(5'h10, 32'h0000_0077);
        rd(5'h10, v);
        repeat (3) @(negedge clk);
        chk("R10 rdata holds", rdata, 32'h0000_0077);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 5'h10; wdata = 32'h0000_0005;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
        chk("R10 write wins, no read", rdata, 32'h0000_0077);
        rd(5'h10, v);
        chk("R10 write done", v, 32'h0000_0005);
        clean();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_mask();
        t_hw();
        t_set();
        t_cor();
        t_masked();
        t_race();
        t_edge();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule